// File: doc/BRIEF.md
# Flash Reset and Auto-Sleep Controller

This block sequences the hardware reset pin and the automatic low-power mode of a flash memory front end, with every time expressed in clock cycles. It filters the active-low reset pin so that only pulses of a qualifying length take effect. During a qualified pulse it aborts any embedded program or erase, tristates the data outputs and refuses commands. It then holds the ready/busy flag low until the internal reset has finished, and holds reads off until the recovery time after the pin is released. Both finishing times depend on whether an embedded operation was running when the pulse qualified.

Alongside the reset path, an address watch puts the device into automatic sleep once the address bus has stayed unchanged for a threshold number of cycles. The chip-enable and output-enable pins play no part in that decision. While asleep, the output data latch keeps the last word read visible. An address change wakes the device and starts a normal access.

Top module: `flash_rstsleep_ctrl`

## Requirements
- R1: The reset pin counts as a valid reset only at the clock edge where it has been sampled low for T_RP consecutive edges. A shorter low run changes no output.
- R2: From the qualifying edge until the pin is sampled high, cmd_ignore and out_hiz are 1. abort_req is 1 in that window only if emb_busy was 1 at the qualifying edge.
- R3: If emb_busy was 1 at qualification, ready is 0 from the qualifying edge until the edge numbered T_RDY_BUSY, counting the first low sample of the pulse as edge 1. It is 1 from that edge on.
- R4: If emb_busy was 0 at qualification, ready stays 1, and the internal reset completes at edge T_RDY_IDLE, counted the same way.
- R5: read_ok drops at the qualifying edge. It returns at the first edge where the pin has been sampled high for T_RH consecutive edges and the internal reset of R3 or R4 has completed.
- R6: out_hiz is 0 exactly when read_ok is 1 and both ce_n and oe_n were sampled 0.
- R7: sleep becomes 1 once the address has matched its previous sample on T_SLEEP consecutive edges, independent of ce_n and oe_n.
- R8: While sleep stays 1, dq_out keeps its value. An address change clears sleep at that edge, and dq_out then loads dq_in when read_ok is 1 and ce_n and oe_n are both 0.
- R9: A qualifying reset edge clears sleep at that same edge, and sleep stays 0 until reads are allowed again.
- R10: Outside a reset sequence, ready is the inverse of emb_busy sampled at the previous edge.
- R11: The synchronous rst input sets ready=1, read_ok=1, out_hiz=1, cmd_ignore=0, abort_req=0, sleep=0 and dq_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| rst_pin_n | input | 1 | Active-low hardware reset pin |
| addr | input | AW | Address bus |
| emb_busy | input | 1 | Embedded program/erase in progress |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| dq_in | input | DW | Read data from the array |
| abort_req | output | 1 | Request to abort the embedded operation |
| out_hiz | output | 1 | Data output tristate enable |
| ready | output | 1 | Ready (1) / busy (0) flag |
| cmd_ignore | output | 1 | Commands are discarded |
| sleep | output | 1 | Automatic sleep active |
| read_ok | output | 1 | Array reads permitted |
| dq_out | output | DW | Latched output data |

## Verification
The bench builds the block with T_RP=4, T_RDY_BUSY=30, T_RDY_IDLE=10, T_RH=3, T_SLEEP=6, an 8-bit address and 16-bit data. These values are far enough apart that a pulse of exactly four cycles ends with read_ok waiting on the idle completion time, while a long pulse ends with it waiting on the recovery count. The busy case keeps ready low well past pin release. The short sleep threshold makes repeated sleep entry, wake-up and reset-during-sleep common under random stimulus. A pulse of three cycles sits one edge short of qualifying.

// File: rtl/frs_pkg.sv
`timescale 1ns/1ps
package frs_pkg;
  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_HOLD = 2'd1,
    PS_REC  = 2'd2
  } pin_state_e;
endpackage

// File: rtl/frs_pin_seq.sv
`timescale 1ns/1ps
module frs_pin_seq
  import frs_pkg::*;
#(
  parameter int unsigned T_RP       = 4,
  parameter int unsigned T_RDY_BUSY = 30,
  parameter int unsigned T_RDY_IDLE = 10,
  parameter int unsigned T_RH       = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic emb_busy,
  output logic run_nxt,
  output logic abort_req,
  output logic cmd_ignore,
  output logic ready,
  output logic rd_ok
);
  localparam int unsigned M1   = (T_RP > T_RH) ? T_RP : T_RH;
  localparam int unsigned M2   = (T_RDY_BUSY > T_RDY_IDLE) ? T_RDY_BUSY : T_RDY_IDLE;
  localparam int unsigned MAXC = (M1 > M2) ? M1 : M2;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] C_MAX  = CW'(MAXC);
  localparam logic [CW-1:0] C_RP   = CW'(T_RP);
  localparam logic [CW-1:0] C_RH   = CW'(T_RH);
  localparam logic [CW-1:0] C_BUSY = CW'(T_RDY_BUSY);
  localparam logic [CW-1:0] C_IDLE = CW'(T_RDY_IDLE);

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == C_MAX) ? v : v + 1'b1;
  endfunction

  pin_state_e st_q, st_n;
  logic [CW-1:0] lo_q, lo_n, rc_q, rc_n, rh_q, rh_n;
  logic bh_q, bh_n;
  logic pin_low, qual;
  logic [CW-1:0] lim;

  always_comb begin
    pin_low = !pin_n;
    lo_n    = pin_low ? sat_inc(lo_q) : '0;
    qual    = pin_low && (lo_n >= C_RP);
    st_n    = st_q;
    rc_n    = rc_q;
    rh_n    = rh_q;
    bh_n    = bh_q;
    lim     = bh_q ? C_BUSY : C_IDLE;
    if (qual && (st_q != PS_HOLD)) begin
      st_n = PS_HOLD;
      bh_n = emb_busy;
      rc_n = lo_n;
      rh_n = '0;
    end else if (st_q != PS_RUN) begin
      rc_n = sat_inc(rc_q);
      if (pin_low) begin
        rh_n = '0;
      end else begin
        rh_n = sat_inc(rh_q);
        st_n = ((rh_n >= C_RH) && (rc_n >= lim)) ? PS_RUN : PS_REC;
      end
    end
    run_nxt = (st_n == PS_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= PS_RUN;
      lo_q       <= '0;
      rc_q       <= '0;
      rh_q       <= '0;
      bh_q       <= 1'b0;
      abort_req  <= 1'b0;
      cmd_ignore <= 1'b0;
      ready      <= 1'b1;
      rd_ok      <= 1'b1;
    end else begin
      st_q       <= st_n;
      lo_q       <= lo_n;
      rc_q       <= rc_n;
      rh_q       <= rh_n;
      bh_q       <= bh_n;
      abort_req  <= (st_n == PS_HOLD) && bh_n;
      cmd_ignore <= (st_n == PS_HOLD);
      ready      <= run_nxt ? !emb_busy : !(bh_n && (rc_n < C_BUSY));
      rd_ok      <= run_nxt;
    end
  end

  // R1: a command lockout can only start on an edge where the pin was low
  a_r1_qual_pin_low: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_ignore) |-> !$past(pin_n));
  // R5: reads come back only on an edge where the pin was sampled high
  a_r5_release_high: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_ok) |-> $past(pin_n));
  // R2: abort is only raised inside the command lockout
  a_r2_abort_in_hold: assert property (@(posedge clk) disable iff (rst)
    abort_req |-> cmd_ignore);
endmodule

// File: rtl/frs_idle_timer.sv
`timescale 1ns/1ps
module frs_idle_timer #(
  parameter int unsigned AW      = 8,
  parameter int unsigned T_SLEEP = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          run_nxt,
  output logic          sleep_nxt,
  output logic          sleep
);
  localparam int unsigned SW = $clog2(T_SLEEP + 1);
  localparam logic [SW-1:0] S_LIM = SW'(T_SLEEP);

  logic [AW-1:0] prev_q;
  logic [SW-1:0] cnt_q, cnt_n;
  logic          moved;

  always_comb begin
    moved     = (addr != prev_q);
    if (moved || !run_nxt)    cnt_n = '0;
    else if (cnt_q == S_LIM)  cnt_n = cnt_q;
    else                      cnt_n = cnt_q + 1'b1;
    sleep_nxt = (cnt_n >= S_LIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      cnt_q  <= '0;
      sleep  <= 1'b0;
    end else begin
      prev_q <= addr;
      cnt_q  <= cnt_n;
      sleep  <= sleep_nxt;
    end
  end

  // R8: an address change while asleep wakes the device at the next edge
  a_r8_wake_on_move: assert property (@(posedge clk) disable iff (rst)
    (sleep && (addr != prev_q)) |=> !sleep);
endmodule

// File: rtl/flash_rstsleep_ctrl.sv
`timescale 1ns/1ps
module flash_rstsleep_ctrl #(
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 16,
  parameter int unsigned T_RP       = 4,
  parameter int unsigned T_RDY_BUSY = 30,
  parameter int unsigned T_RDY_IDLE = 10,
  parameter int unsigned T_RH       = 3,
  parameter int unsigned T_SLEEP    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rst_pin_n,
  input  logic [AW-1:0] addr,
  input  logic          emb_busy,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [DW-1:0] dq_in,
  output logic          abort_req,
  output logic          out_hiz,
  output logic          ready,
  output logic          cmd_ignore,
  output logic          sleep,
  output logic          read_ok,
  output logic [DW-1:0] dq_out
);
  logic run_nxt, sleep_nxt, rd_en;

  frs_pin_seq #(
    .T_RP(T_RP), .T_RDY_BUSY(T_RDY_BUSY), .T_RDY_IDLE(T_RDY_IDLE), .T_RH(T_RH)
  ) u_pin (
    .clk(clk), .rst(rst), .pin_n(rst_pin_n), .emb_busy(emb_busy),
    .run_nxt(run_nxt), .abort_req(abort_req), .cmd_ignore(cmd_ignore),
    .ready(ready), .rd_ok(read_ok)
  );

  frs_idle_timer #(.AW(AW), .T_SLEEP(T_SLEEP)) u_idle (
    .clk(clk), .rst(rst), .addr(addr), .run_nxt(run_nxt),
    .sleep_nxt(sleep_nxt), .sleep(sleep)
  );

  assign rd_en = run_nxt && !ce_n && !oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_hiz <= 1'b1;
      dq_out  <= '0;
    end else begin
      out_hiz <= !rd_en;
      if (rd_en && !sleep_nxt) dq_out <= dq_in;
    end
  end

  // R2: commands locked out implies outputs tristated
  a_r2_lockout_hiz: assert property (@(posedge clk) disable iff (rst)
    cmd_ignore |-> out_hiz);
  // R6: no drive while reads are barred
  a_r6_noread_hiz: assert property (@(posedge clk) disable iff (rst)
    !read_ok |-> out_hiz);
  // R9: a qualified reset never coexists with sleep
  a_r9_lockout_awake: assert property (@(posedge clk) disable iff (rst)
    cmd_ignore |-> !sleep);
  // R8: data frozen across consecutive sleeping cycles
  a_r8_dq_frozen: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (!sleep || $stable(dq_out)));
endmodule

// File: tb/flash_rstsleep_ctrl_tb.sv
`timescale 1ns/1ps
module flash_rstsleep_ctrl_tb;
  localparam int AW = 8, DW = 16;
  localparam int T_RP = 4, T_RDY_BUSY = 30, T_RDY_IDLE = 10, T_RH = 3, T_SLEEP = 6;

  logic clk = 0, rst = 1, rst_pin_n = 1, emb_busy = 0, ce_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic abort_req, out_hiz, ready, cmd_ignore, sleep, read_ok;
  logic [DW-1:0] dq_out;

  int n_chk = 0, n_fail = 0;

  // reference state
  int m_phase = 0; // 0 run, 1 hold, 2 recover
  int m_low = 0, m_since = 0, m_hi = 0, m_stab = 0;
  bit m_bh = 0;
  logic [AW-1:0] m_prev = '0;
  bit e_abort = 0, e_hiz = 1, e_ready = 1, e_ign = 0, e_sleep = 0, e_rdok = 1;
  logic [DW-1:0] e_dq = '0;

  flash_rstsleep_ctrl #(.AW(AW), .DW(DW), .T_RP(T_RP), .T_RDY_BUSY(T_RDY_BUSY),
    .T_RDY_IDLE(T_RDY_IDLE), .T_RH(T_RH), .T_SLEEP(T_SLEEP)) u_dut (
    .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .addr(addr), .emb_busy(emb_busy),
    .ce_n(ce_n), .oe_n(oe_n), .dq_in(dq_in), .abort_req(abort_req), .out_hiz(out_hiz),
    .ready(ready), .cmd_ignore(cmd_ignore), .sleep(sleep), .read_ok(read_ok), .dq_out(dq_out));

  always #4 clk = ~clk;

  task automatic cmp(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int done_lim(input bit bh);
    return bh ? T_RDY_BUSY : T_RDY_IDLE;
  endfunction

  task automatic model_step();
    bit pl, q, run, slp;
    if (rst) begin
      m_phase = 0; m_low = 0; m_since = 0; m_hi = 0; m_stab = 0; m_bh = 0;
      m_prev = '0; e_abort = 0; e_hiz = 1; e_ready = 1; e_ign = 0; e_sleep = 0;
      e_rdok = 1; e_dq = '0;
      return;
    end
    pl = !rst_pin_n;
    m_low = pl ? m_low + 1 : 0;
    q = pl && (m_low >= T_RP);
    if (q && m_phase != 1) begin
      m_phase = 1; m_bh = emb_busy; m_since = m_low; m_hi = 0;
    end else if (m_phase != 0) begin
      m_since++;
      if (pl) m_hi = 0;
      else begin
        m_hi++;
        m_phase = (m_hi >= T_RH && m_since >= done_lim(m_bh)) ? 0 : 2;
      end
    end
    run = (m_phase == 0);
    m_stab = (addr != m_prev || !run) ? 0 : m_stab + 1;
    m_prev = addr;
    slp = (m_stab >= T_SLEEP);
    e_ign = (m_phase == 1);
    e_abort = e_ign && m_bh;
    e_ready = run ? !emb_busy : !(m_bh && m_since < T_RDY_BUSY);
    e_rdok = run;
    e_hiz = !(run && !ce_n && !oe_n);
    if (run && !ce_n && !oe_n && !slp) e_dq = dq_in;
    e_sleep = slp;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #2;
    cmp(cmd_ignore, e_ign, "R2 cmd_ignore");
    cmp(abort_req, e_abort, "R2 abort_req");
    cmp(ready, e_ready, "R3/R4/R10 ready");
    cmp(read_ok, e_rdok, "R5 read_ok");
    cmp(out_hiz, e_hiz, "R6 out_hiz");
    cmp(sleep, e_sleep, "R7 sleep");
    cmp(dq_out, e_dq, "R8 dq_out");
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    ticks(3);
    rst = 0;
    tick();
    cmp(ready, 1, "R11 ready after reset");
    cmp(dq_out, 0, "R11 dq_out after reset");
    // normal reads
    ce_n = 0; oe_n = 0; addr = 8'h05; dq_in = 16'hA5A5;
    ticks(3);
    cmp(dq_out, 16'hA5A5, "R8 normal load");
    // one edge short of qualifying
    rst_pin_n = 0;
    ticks(T_RP - 1);
    cmp(cmd_ignore, 0, "R1 short pulse ignored");
    cmp(read_ok, 1, "R1 read_ok unaffected");
    rst_pin_n = 1; addr = 8'h06;
    ticks(5);
    // reset during busy operation
    emb_busy = 1;
    tick();
    cmp(ready, 0, "R10 busy flag");
    rst_pin_n = 0;
    ticks(T_RP);
    cmp(abort_req, 1, "R2 abort when busy");
    ticks(8);
    emb_busy = 0; rst_pin_n = 1;
    ticks(40);
    // exact minimum idle pulse
    rst_pin_n = 0; addr = 8'h10;
    ticks(T_RP);
    cmp(cmd_ignore, 1, "R1 exact pulse qualifies");
    cmp(ready, 1, "R4 ready stays high idle");
    rst_pin_n = 1;
    ticks(15);
    // long idle pulse
    rst_pin_n = 0;
    ticks(20);
    rst_pin_n = 1;
    ticks(8);
    // sleep then reset during sleep
    addr = 8'h33;
    ticks(10);
    cmp(sleep, 1, "R7 sleep entered");
    dq_in = 16'h1234;
    rst_pin_n = 0;
    ticks(T_RP - 1);
    cmp(sleep, 1, "R7 sleep before qualification");
    cmp(dq_out, 16'hA5A5, "R8 dq held in sleep");
    tick();
    cmp(sleep, 0, "R9 sleep cleared by reset");
    rst_pin_n = 1;
    ticks(15);
    // wake by address change
    ticks(8);
    addr = 8'h34;
    tick();
    cmp(sleep, 0, "R8 wake on address change");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (!rst_pin_n) begin
        if ($urandom % 5 == 0) rst_pin_n = 1;
      end else if ($urandom % 40 == 0) rst_pin_n = 0;
      if ($urandom % 8 == 0) addr = AW'($urandom);
      if ($urandom % 12 == 0) emb_busy = ~emb_busy;
      if ($urandom % 6 == 0) ce_n = ~ce_n;
      if ($urandom % 6 == 0) oe_n = ~oe_n;
      dq_in = DW'($urandom);
      tick();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule